// File: doc/BRIEF.md
# Reloadable 56-bit Event Timer

This block is a memory-mapped countdown timer with a 56-bit reach. It signals expiry through a single interrupt line and runs either once or periodically. Software stores the reload value in two steps. It first writes the low 32 bits to their own register. It then writes the control word, which carries the upper 24 bits, the run bit, the periodic bit and a load strobe. That single control write commits the whole 56-bit value into the counter, selects the mode and starts the count.

Three write-one registers handle the interrupt: one sets the enable, one clears it, and one clears the pending flag. Expiry always marks the pending flag. The interrupt line is high while the flag is pending and the enable is set. A read port returns the stored low word, the control word, the interrupt enable and the pending flag.

Top module: `evt_timer56`

## Requirements
- R1: After reset the interrupt output is low. Reads of offsets 0x000, 0x004, 0x02c and 0x034 all return 0.
- R2: A write to offset 0x000 stores reload bits [31:0], and a read of 0x000 returns them.
- R3: A write to control offset 0x004 takes reload bits [55:32] from data bits [23:0], the run bit from bit 24, the periodic bit from bit 28 and the load strobe from bit 30. A read of 0x004 returns the upper reload bits, the run bit and the periodic bit in those positions, with bit 30 always 0.
- R4: When a control write sets the load strobe and the run bit with a reload value N of at least 2, the first expiry sets the pending flag exactly N clock cycles after the clock edge that took the write.
- R5: Reload values 0 and 1 behave as 2, both when loaded and when reloaded.
- R6: With the periodic bit set, the counter reloads on each expiry from the stored 56-bit value and keeps running, so expiries occur every N cycles.
- R7: With the periodic bit clear, the timer stops at expiry. The run bit then reads 0, and no further expiry happens.
- R8: A control write of 0 stops the count before expiry. No interrupt follows, and the control word then reads 0.
- R9: Writing 1 to bit 0 of 0x02c sets the interrupt enable, and writing 1 to bit 0 of 0x030 clears it. A write with bit 0 at 0 to either offset changes nothing. Bit 0 of a read at 0x02c shows the enable.
- R10: Expiry sets the pending flag whether or not the interrupt is enabled, and bit 0 of a read at 0x034 shows the flag. The interrupt output equals the pending flag AND the enable.
- R11: Writing 1 to bit 0 of 0x034 clears the pending flag, and a write with bit 0 at 0 has no effect. If an expiry happens in the same cycle, the expiry wins.
- R12: A control write that sets the run bit without the load strobe resumes from the held count. If the held count is zero, the counter takes the reload value instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Interrupt, pending AND enable |

## Verification
The hardest state to reach from the ports is a held, partly run count. That is a timer stopped in mid-count and later restarted without a load, together with the case where the held count is already zero after a one-shot expiry. The stimulus starts a count, stops it with a zero control write after a known number of cycles, and idles. It then issues a run-only control write and measures the cycles to the interrupt against the remainder. A second run-only write, issued after a one-shot expiry, checks that the stored reload value is taken.

// File: rtl/evt_timer56_pkg.sv
package evt_timer56_pkg;
  // register offsets (bytes)
  localparam logic [7:0] OFS_RLD_LO   = 8'h00;
  localparam logic [7:0] OFS_CTRL     = 8'h04;
  localparam logic [7:0] OFS_IE_SET   = 8'h2C;
  localparam logic [7:0] OFS_IE_CLR   = 8'h30;
  localparam logic [7:0] OFS_PEND_CLR = 8'h34;

  // control word bit positions
  localparam int CTL_RUN_BIT = 24;
  localparam int CTL_RPT_BIT = 28;
  localparam int CTL_LD_BIT  = 30;

  typedef struct packed {
    logic lo_wr;
    logic ctl_wr;
    logic ld;
    logic run;
    logic rpt;
    logic ie_set;
    logic ie_clr;
    logic pend_clr;
  } wr_dec_t;
endpackage

// File: rtl/evt_timer56_regs.sv
module evt_timer56_regs
  import evt_timer56_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 56,
  parameter int ADDR_W = 8,
  localparam int HI_W  = CNT_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_dec_t           dec,
  output logic [DATA_W-1:0] lo_q,
  output logic [HI_W-1:0]   hi_q
);
  always_comb begin
    dec          = '0;
    dec.lo_wr    = wr_en && (wr_addr == ADDR_W'(OFS_RLD_LO));
    dec.ctl_wr   = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    dec.ld       = wr_data[CTL_LD_BIT];
    dec.run      = wr_data[CTL_RUN_BIT];
    dec.rpt      = wr_data[CTL_RPT_BIT];
    dec.ie_set   = wr_en && (wr_addr == ADDR_W'(OFS_IE_SET))   && wr_data[0];
    dec.ie_clr   = wr_en && (wr_addr == ADDR_W'(OFS_IE_CLR))   && wr_data[0];
    dec.pend_clr = wr_en && (wr_addr == ADDR_W'(OFS_PEND_CLR)) && wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (dec.lo_wr)  lo_q <= wr_data;
      if (dec.ctl_wr) hi_q <= wr_data[HI_W-1:0];
    end
  end
endmodule

// File: rtl/evt_timer56_counter.sv
module evt_timer56_counter #(
  parameter int CNT_W     = 56,
  parameter int MIN_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ld,
  input  logic             run_wr,
  input  logic             rpt_wr,
  input  logic [CNT_W-1:0] new_val,
  input  logic [CNT_W-1:0] rld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             rpt_q,
  output logic             expire
);
  logic [CNT_W-1:0] new_eff, rld_eff, cnt_d;
  logic             run_d, rpt_d, cnt_en;

  // lower bound on the programmed delay
  generate
    if (MIN_TICKS > 1) begin : g_clamp
      assign new_eff = (new_val < CNT_W'(MIN_TICKS)) ? CNT_W'(MIN_TICKS) : new_val;
      assign rld_eff = (rld_val < CNT_W'(MIN_TICKS)) ? CNT_W'(MIN_TICKS) : rld_val;
    end else begin : g_pass
      assign new_eff = new_val;
      assign rld_eff = rld_val;
    end
  endgenerate

  // a control write in the expiry cycle takes precedence
  assign expire = run_q && (cnt_q == CNT_W'(1)) && !ctl_wr;
  assign cnt_en = ctl_wr || run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    rpt_d = rpt_q;
    if (ctl_wr) begin
      run_d = run_wr;
      rpt_d = rpt_wr;
      if (ld || (run_wr && cnt_q == '0)) cnt_d = new_eff;
    end else if (run_q) begin
      if (cnt_q == CNT_W'(1)) begin
        if (rpt_q) begin
          cnt_d = rld_eff;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      rpt_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      rpt_q <= rpt_d;
    end
  end
endmodule

// File: rtl/evt_timer56_irq.sv
module evt_timer56_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ie_set,
  input  logic ie_clr,
  input  logic pend_clr,
  output logic ie_q,
  output logic pend_q,
  output logic irq_o
);
  logic ie_d, pend_d;

  always_comb begin
    ie_d = ie_q;
    if (ie_set)      ie_d = 1'b1;
    else if (ie_clr) ie_d = 1'b0;
    pend_d = pend_q;
    if (expire)        pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      pend_q <= pend_d;
    end
  end

  assign irq_o = pend_q & ie_q;
endmodule

// File: rtl/evt_timer56.sv
module evt_timer56
  import evt_timer56_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 56,
  parameter int ADDR_W    = 8,
  parameter int MIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int HI_W = CNT_W - DATA_W;

  wr_dec_t          dec;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, rpt_q, expire, ie_q, pend_q;
  logic [DATA_W-1:0] ctl_rd;

  evt_timer56_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dec(dec), .lo_q(lo_q), .hi_q(hi_q)
  );

  evt_timer56_counter #(.CNT_W(CNT_W), .MIN_TICKS(MIN_TICKS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(dec.ctl_wr), .ld(dec.ld),
    .run_wr(dec.run), .rpt_wr(dec.rpt),
    .new_val({wr_data[HI_W-1:0], lo_q}), .rld_val({hi_q, lo_q}),
    .cnt_q(cnt_q), .run_q(run_q), .rpt_q(rpt_q), .expire(expire)
  );

  evt_timer56_irq irq_i (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ie_set(dec.ie_set),
    .ie_clr(dec.ie_clr), .pend_clr(dec.pend_clr),
    .ie_q(ie_q), .pend_q(pend_q), .irq_o(irq_o)
  );

  always_comb begin
    ctl_rd              = '0;
    ctl_rd[HI_W-1:0]    = hi_q;
    ctl_rd[CTL_RUN_BIT] = run_q;
    ctl_rd[CTL_RPT_BIT] = rpt_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_RLD_LO))        rd_data = lo_q;
    else if (rd_addr == ADDR_W'(OFS_CTRL))     rd_data = ctl_rd;
    else if (rd_addr == ADDR_W'(OFS_IE_SET))   rd_data[0] = ie_q;
    else if (rd_addr == ADDR_W'(OFS_PEND_CLR)) rd_data[0] = pend_q;
  end
endmodule

// File: rtl/evt_timer56_chk.sv
module evt_timer56_chk #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 56,
  parameter int ADDR_W    = 8,
  parameter int MIN_TICKS = 2,
  localparam int HI_W     = CNT_W - DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              expire,
  input logic              run_q,
  input logic              rpt_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              pend_q,
  input logic [DATA_W-1:0] lo_q,
  input logic [HI_W-1:0]   hi_q
);
  function automatic logic [CNT_W-1:0] floor_ticks(input logic [CNT_W-1:0] v);
    return (v < CNT_W'(MIN_TICKS)) ? CNT_W'(MIN_TICKS) : v;
  endfunction

  logic ctl_hit;
  assign ctl_hit = wr_en && (wr_addr == ADDR_W'(8'h04));

  assert_load_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && wr_data[30]) |=> cnt_q == floor_ticks({$past(wr_data[HI_W-1:0]), $past(lo_q)}));

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rpt_q) |=> (run_q && cnt_q == floor_ticks({$past(hi_q), $past(lo_q)})));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rpt_q) |=> !run_q);

  assert_zero_write_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && wr_data == '0) |=> !run_q);

  assert_pend_only_on_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(expire));

  assert_pend_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(8'h34) && wr_data[0] && !expire) |=> !pend_q);

  assert_running_count_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);
endmodule

bind evt_timer56 evt_timer56_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MIN_TICKS(MIN_TICKS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .expire(expire), .run_q(run_q), .rpt_q(rpt_q), .cnt_q(cnt_q),
  .pend_q(pend_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/evt_timer56_tb_top.sv
module evt_timer56_tb_top;
  localparam logic [7:0] A_LO = 8'h00, A_CTL = 8'h04, A_IES = 8'h2C, A_IEC = 8'h30, A_PCL = 8'h34;
  localparam logic [31:0] EN = 32'h0100_0000, RPT = 32'h1000_0000, LD = 32'h4000_0000;

  typedef struct packed {
    logic [31:0] lo;
    logic        rpt;
    logic [15:0] exp_n;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{lo: 32'd5,  rpt: 1'b0, exp_n: 16'd5},
    '{lo: 32'd2,  rpt: 1'b1, exp_n: 16'd2},
    '{lo: 32'd1,  rpt: 1'b0, exp_n: 16'd2},
    '{lo: 32'd0,  rpt: 1'b1, exp_n: 16'd2},
    '{lo: 32'd37, rpt: 1'b1, exp_n: 16'd37},
    '{lo: 32'd12, rpt: 1'b0, exp_n: 16'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer56 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the following rising edge takes the write
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_irq(inout int k, input int limit);
    do begin @(negedge clk); k++; end while (!irq_o && k < limit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    rd(A_LO, d);  chk(d == 0, "R1 lo", d, 0);
    rd(A_CTL, d); chk(d == 0, "R1 ctl", d, 0);
    rd(A_IES, d); chk(d == 0, "R1 ie", d, 0);
    rd(A_PCL, d); chk(d == 0, "R1 pend", d, 0);

    // R2 / R3 field placement and readback
    wr(A_LO, 32'hDEAD_BEEF);
    rd(A_LO, d); chk(d == 32'hDEAD_BEEF, "R2 lo readback", d, 32'hDEAD_BEEF);
    wr(A_CTL, 32'h00AB_CDEF | RPT | LD);
    rd(A_CTL, d); chk(d == 32'h10AB_CDEF, "R3 ctl readback", d, 32'h10AB_CDEF);
    wr(A_CTL, 32'h0000_0000);

    // vector table: delay, clamp, periodic, one-shot
    wr(A_IES, 32'd1);
    for (int i = 0; i < NV; i++) begin
      wr(A_CTL, 0);
      wr(A_PCL, 1);
      wr(A_LO, VECS[i].lo);
      wr(A_CTL, EN | LD | (VECS[i].rpt ? RPT : 32'd0));
      k = 0;
      wait_irq(k, 200);
      chk(k == int'(VECS[i].exp_n), (VECS[i].lo < 2) ? "R5 first expiry" : "R4 first expiry",
          k, VECS[i].exp_n);
      wr(A_PCL, 1); k++;
      if (VECS[i].rpt) begin
        wait_irq(k, 400);
        chk(k == 2 * int'(VECS[i].exp_n), "R6 second expiry", k, 2 * VECS[i].exp_n);
      end else begin
        repeat (3 * int'(VECS[i].exp_n)) @(negedge clk);
        chk(irq_o == 1'b0, "R7 no re-expiry", irq_o, 0);
        rd(A_CTL, d); chk(d[24] == 1'b0, "R7 run bit cleared", d[24], 0);
      end
    end

    // R8 stop by zero write
    wr(A_CTL, 0); wr(A_PCL, 1);
    wr(A_LO, 32'd20);
    wr(A_CTL, EN | LD);
    repeat (5) @(negedge clk);
    wr(A_CTL, 0);
    repeat (30) @(negedge clk);
    chk(irq_o == 1'b0, "R8 irq after stop", irq_o, 0);
    rd(A_PCL, d); chk(d == 0, "R8 pending after stop", d, 0);
    rd(A_CTL, d); chk(d == 0, "R8 ctl after stop", d, 0);

    // R9 / R10 enable versus pending
    wr(A_IEC, 1);
    rd(A_IES, d); chk(d == 0, "R9 enable cleared", d, 0);
    wr(A_LO, 32'd4);
    wr(A_CTL, EN | LD);
    repeat (6) @(negedge clk);
    rd(A_PCL, d); chk(d == 1, "R10 pending while disabled", d, 1);
    chk(irq_o == 1'b0, "R10 irq masked", irq_o, 0);
    wr(A_IES, 1);
    chk(irq_o == 1'b1, "R10 irq after enable", irq_o, 1);
    wr(A_IEC, 0);
    rd(A_IES, d); chk(d == 1 && irq_o, "R9 zero write ignored", d, 1);
    wr(A_IES, 0);
    rd(A_IES, d); chk(d == 1, "R9 zero set write ignored", d, 1);
    wr(A_IEC, 1);
    chk(irq_o == 1'b0, "R9 irq after disable", irq_o, 0);
    wr(A_IES, 1);

    // R11 pending clear
    wr(A_PCL, 0);
    rd(A_PCL, d); chk(d == 1, "R11 zero clear ignored", d, 1);
    wr(A_PCL, 1);
    rd(A_PCL, d); chk(d == 0, "R11 pending cleared", d, 0);
    chk(irq_o == 1'b0, "R11 irq cleared", irq_o, 0);

    // R12 resume from held count, then from zero
    wr(A_LO, 32'd10);
    wr(A_CTL, EN | LD);
    repeat (4) @(negedge clk);
    wr(A_CTL, 0);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b0, "R12 held no irq", irq_o, 0);
    wr(A_CTL, EN);
    k = 0;
    wait_irq(k, 100);
    chk(k == 6, "R12 resume remainder", k, 6);
    wr(A_PCL, 1);
    wr(A_CTL, EN);
    k = 0;
    wait_irq(k, 100);
    chk(k == 10, "R12 resume from zero", k, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule